// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block places a small cache in front of a slow, word-wide main memory. A processor issues single-word reads and writes on a 16-bit word address. The cache keeps 128 lines of 16 words. Each line has a tag, a valid flag and a dirty flag. A lookup that hits finishes in the same cycle as the request. A miss starts a memory transaction: if the line being replaced holds modified data, those 16 words are first written out, then the new line is read in one word per memory handshake.

Writes that hit stay in the cache and mark the line modified. A write that misses allocates the line first and then merges the new word. During a refill the processor is released as soon as its own word arrives. The rest of the line keeps streaming in, and any new request waits until the refill is done. A separate invalidate input names a memory block that something else has changed. If that block is resident, or is being refilled, it ends up invalid.

The controller has three states. `ST_IDLE` serves hits and takes transition *miss-dirty* to `ST_WBACK` or *miss-clean* to `ST_FILL`. `ST_WBACK` takes transition *flush-done* to `ST_FILL` after the sixteenth write handshake. `ST_FILL` takes transition *fill-done* back to `ST_IDLE` after the sixteenth read handshake.

Top module: `dmc_cache`

## Requirements
- R1: The address splits into word offset `addr[3:0]`, line index `addr[10:4]` and tag `addr[15:11]`. Memory block j (`addr[15:4]`) can live only in line j mod 128, and words of one block that differ only in offset hit the same line.
- R2: After reset `cpu_ready` and `mem_req` are low and every line is invalid, so the first access to any block misses.
- R3: A read hit raises `cpu_ready` in the cycle the request is presented, returns the cached word, and causes no memory handshake.
- R4: A write hit completes in the request cycle and updates only the cache. Memory keeps its old value until the line is evicted.
- R5: A miss reads all 16 words of the block from memory, starting at offset 0 and going up by one per `mem_ack`. The line then becomes valid, and `mem_req` drops in the cycle after the last word.
- R6: Before the refill, a dirty victim is written back as 16 words at the victim's own address, offsets 0 to 15 in ascending order. The refill reads begin only after the last write, and `cpu_ready` never rises during the writeback.
- R7: On a read miss with offset k, `cpu_ready` rises in the cycle of the (k+1)-th refill acknowledge, with `cpu_rdata` equal to the word just returned.
- R8: A write miss fetches the block, puts the processor's word at its offset, completes at the (k+1)-th refill acknowledge, and leaves the line dirty so that a later eviction writes the new word to memory.
- R9: A miss always replaces the line at its index, whatever that line held. An access to the previous block then misses.
- R10: A one-cycle `inv_valid` with block address `inv_block` (= `addr[15:4]`) clears the line when the tag matches. Any modified data in that line is discarded without a writeback. A block address with another tag at the same index has no effect.
- R11: If the block being refilled is invalidated at any point before its refill ends, the requested word is still delivered, but the line ends invalid. Invalidating another block at the same index leaves the refilled line valid.
- R12: While `mem_req` is high and `mem_ack` is low, `mem_addr` and `mem_we` hold steady. Exactly one word moves on each `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data, held with the request |
| cpu_rdata | output | 16 | Read data, valid when `cpu_ready` is high |
| cpu_ready | output | 1 | Request completes at this clock edge |
| inv_valid | input | 1 | Invalidate strobe, one cycle |
| inv_block | input | 12 | Block address to invalidate |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Word written to memory |
| mem_ack | input | 1 | Memory completes the current word |
| mem_rdata | input | 16 | Word read from memory, valid with `mem_ack` |

## Verification
A sweep of read misses covers every word offset, each on its own line, to tell the critical-word release point apart from a fill that starts at the wrong word or waits for the whole line. A second sweep re-reads all sixteen words of a loaded line, to separate true hits from hidden memory traffic. Conflict sequences on a shared index (clean victim, dirty victim after a write hit, write-miss allocation) distinguish write-back from write-through and show whether the flush reaches memory ahead of the refill. Invalidations are issued with matching and non-matching tags, on idle and dirty lines, and in the middle of a refill, to show which of them actually clear the line.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
    parameter int IDX_W = 7,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_valid,
    input  logic             upd_dirty,
    input  logic             dset_en,
    input  logic [IDX_W-1:0] dset_idx,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic [TAG_W-1:0] inv_tag
);
    localparam int NLINE = 1 << IDX_W;

    logic [TAG_W-1:0] tags [NLINE];
    logic [NLINE-1:0] valid_q;
    logic [NLINE-1:0] dirty_q;
    logic             inv_match;

    assign rd_tag   = tags[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    // a line being installed this cycle is handled by the controller
    assign inv_match = inv_en && valid_q[inv_idx] && (tags[inv_idx] == inv_tag)
                       && !(upd_en && (upd_idx == inv_idx));

    always_ff @(posedge clk) begin
        if (upd_en) begin
            tags[upd_idx] <= upd_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (upd_en) begin
                valid_q[upd_idx] <= upd_valid;
                dirty_q[upd_idx] <= upd_dirty;
            end
            if (dset_en) begin
                dirty_q[dset_idx] <= 1'b1;
            end
            if (inv_match) begin
                valid_q[inv_idx] <= 1'b0;
                dirty_q[inv_idx] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
    parameter int IDX_W  = 7,
    parameter int OFFS_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic [IDX_W+OFFS_W-1:0] rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [IDX_W+OFFS_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]       wr_data
);
    localparam int NWORDS = 1 << (IDX_W + OFFS_W);

    logic [DATA_W-1:0] words [NWORDS];

    assign rd_data = words[rd_addr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFFS_W = 4,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - OFFS_W - IDX_W,
    localparam int BLK_W = ADDR_W - OFFS_W,
    localparam int LOC_W = IDX_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              inv_valid,
    input  logic [BLK_W-1:0]  inv_block,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_valid,
    input  logic              lk_dirty,
    output logic              upd_en,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [TAG_W-1:0]  upd_tag,
    output logic              upd_valid,
    output logic              upd_dirty,
    output logic              dset_en,
    output logic [IDX_W-1:0]  dset_idx,
    output logic [LOC_W-1:0]  dat_raddr,
    input  logic [DATA_W-1:0] dat_rdata,
    output logic              dat_we,
    output logic [LOC_W-1:0]  dat_waddr,
    output logic [DATA_W-1:0] dat_wdata
);
    localparam logic [OFFS_W-1:0] LAST_OFF = {OFFS_W{1'b1}};

    dmc_state_e        state_q, state_d;
    logic [OFFS_W-1:0] cnt_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [TAG_W-1:0]  vict_tag_q;
    logic              kill_q;

    logic [TAG_W-1:0]  cpu_tag, req_tag;
    logic [IDX_W-1:0]  cpu_idx, req_idx;
    logic [OFFS_W-1:0] cpu_off, req_off;
    logic              lk_hit, last_word, inv_on_req, inv_on_cpu, take_miss;

    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign cpu_idx = cpu_addr[OFFS_W +: IDX_W];
    assign cpu_off = cpu_addr[OFFS_W-1:0];
    assign req_tag = req_addr_q[ADDR_W-1 -: TAG_W];
    assign req_idx = req_addr_q[OFFS_W +: IDX_W];
    assign req_off = req_addr_q[OFFS_W-1:0];

    assign lk_idx     = (state_q == ST_IDLE) ? cpu_idx : req_idx;
    assign lk_hit     = lk_valid && (lk_tag == cpu_tag);
    assign last_word  = (cnt_q == LAST_OFF);
    assign inv_on_req = inv_valid && (inv_block == req_addr_q[ADDR_W-1:OFFS_W]);
    assign inv_on_cpu = inv_valid && (inv_block == cpu_addr[ADDR_W-1:OFFS_W]);
    assign take_miss  = (state_q == ST_IDLE) && cpu_req && !lk_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_miss) begin
                    state_d = (lk_valid && lk_dirty) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                if (mem_ack && last_word) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ack && last_word) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // miss bookkeeping: request copy, word counter, invalidate memory
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            req_addr_q <= '0;
            req_we_q   <= 1'b0;
            vict_tag_q <= '0;
            kill_q     <= 1'b0;
        end else if (take_miss) begin
            cnt_q      <= '0;
            req_addr_q <= cpu_addr;
            req_we_q   <= cpu_we;
            vict_tag_q <= lk_tag;
            kill_q     <= inv_on_cpu;
        end else if (state_q != ST_IDLE) begin
            if (mem_ack) cnt_q <= cnt_q + 1'b1;
            if (inv_on_req) kill_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = dat_rdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_tag, req_idx, cnt_q};
        mem_wdata = '0;
        dat_raddr = {cpu_idx, cpu_off};
        dat_we    = 1'b0;
        dat_waddr = {req_idx, cnt_q};
        dat_wdata = mem_rdata;
        dset_en   = 1'b0;
        dset_idx  = cpu_idx;
        upd_en    = 1'b0;
        upd_idx   = req_idx;
        upd_tag   = req_tag;
        upd_valid = 1'b0;
        upd_dirty = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && lk_hit) begin
                    cpu_ready = 1'b1;
                    if (cpu_we) begin
                        dat_we    = 1'b1;
                        dat_waddr = {cpu_idx, cpu_off};
                        dat_wdata = cpu_wdata;
                        dset_en   = 1'b1;
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {vict_tag_q, req_idx, cnt_q};
                dat_raddr = {req_idx, cnt_q};
                mem_wdata = dat_rdata;
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                cpu_rdata = mem_rdata;
                if (mem_ack) begin
                    dat_we = 1'b1;
                    if (cnt_q == req_off) begin
                        cpu_ready = 1'b1;
                        if (req_we_q) dat_wdata = cpu_wdata;
                    end
                    if (last_word) begin
                        upd_en    = 1'b1;
                        upd_valid = !(kill_q || inv_on_req);
                        upd_dirty = req_we_q;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFFS_W = 4,
    parameter int IDX_W  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_ready,
    input  logic                     inv_valid,
    input  logic [ADDR_W-OFFS_W-1:0] inv_block,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_ack,
    input  logic [DATA_W-1:0]        mem_rdata
);
    localparam int TAG_W = ADDR_W - OFFS_W - IDX_W;
    localparam int BLK_W = ADDR_W - OFFS_W;
    localparam int LOC_W = IDX_W + OFFS_W;

    logic [IDX_W-1:0]  lk_idx, upd_idx, dset_idx;
    logic [TAG_W-1:0]  lk_tag, upd_tag;
    logic              lk_valid, lk_dirty, upd_en, upd_valid, upd_dirty, dset_en;
    logic [LOC_W-1:0]  dat_raddr, dat_waddr;
    logic [DATA_W-1:0] dat_rdata, dat_wdata;
    logic              dat_we;

    dmc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .inv_valid(inv_valid), .inv_block(inv_block),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_tag(upd_tag),
        .upd_valid(upd_valid), .upd_dirty(upd_dirty),
        .dset_en(dset_en), .dset_idx(dset_idx),
        .dat_raddr(dat_raddr), .dat_rdata(dat_rdata),
        .dat_we(dat_we), .dat_waddr(dat_waddr), .dat_wdata(dat_wdata)
    );

    dmc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_valid(lk_valid), .rd_dirty(lk_dirty),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_tag(upd_tag),
        .upd_valid(upd_valid), .upd_dirty(upd_dirty),
        .dset_en(dset_en), .dset_idx(dset_idx),
        .inv_en(inv_valid), .inv_idx(inv_block[IDX_W-1:0]),
        .inv_tag(inv_block[BLK_W-1 -: TAG_W])
    );

    dmc_data_array #(.IDX_W(IDX_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_data (
        .clk(clk),
        .rd_addr(dat_raddr), .rd_data(dat_rdata),
        .wr_en(dat_we), .wr_addr(dat_waddr), .wr_data(dat_wdata)
    );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 16,
    parameter int OFFS_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam logic [OFFS_W-1:0] LAST_OFF = {OFFS_W{1'b1}};

    // R12: a pending word holds its address and direction
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: every burst begins at word 0
    a_r5_start_word0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (mem_addr[OFFS_W-1:0] == '0));

    // R5: refill words go up by one per acknowledge
    a_r5_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && (mem_addr[OFFS_W-1:0] != LAST_OFF))
        |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + 1'b1)));

    // R5: the last refill word ends the transaction
    a_r5_fill_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && (mem_addr[OFFS_W-1:0] == LAST_OFF)) |=> !mem_req);

    // R6: writeback words go up by one per acknowledge
    a_r6_wb_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we && (mem_addr[OFFS_W-1:0] != LAST_OFF))
        |=> (mem_req && mem_we && (mem_addr == $past(mem_addr) + 1'b1)));

    // R6: the refill starts at word 0 right after the last writeback word
    a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we && (mem_addr[OFFS_W-1:0] == LAST_OFF))
        |=> (mem_req && !mem_we && (mem_addr[OFFS_W-1:0] == '0)));

    // R6: the processor is never released during a writeback
    a_r6_no_ready_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !cpu_ready);
endmodule

bind dmc_cache dmc_checker #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_dmc_cache;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        inv_valid = 1'b0;
    logic [11:0] inv_block = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [15:0] mem_rdata;

    int cyc = 0, n_chk = 0, n_fail = 0;
    int rd_n, wr_n, rd_bad, wr_bad, ord_bad, lat_c;
    bit done = 1'b0;

    logic [15:0] mm [logic [15:0]];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dmc_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .inv_valid(inv_valid), .inv_block(inv_block),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] seed_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        if (mm.exists(a)) return mm[a];
        return seed_word(a);
    endfunction

    function automatic logic [15:0] mk(input int t, input int i, input int o);
        return {t[4:0], i[6:0], o[3:0]};
    endfunction

    // memory model: one word per acknowledge after LAT waiting cycles
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_rdata <= '0; lat_c <= 0;
            rd_n <= 0; wr_n <= 0; rd_bad <= 0; wr_bad <= 0; ord_bad <= 0;
        end else if (mem_req && !mem_ack) begin
            if (lat_c == LAT - 1) begin
                lat_c   <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mm[mem_addr] = mem_wdata;
                    wr_n <= wr_n + 1;
                    if (mem_addr[3:0] != wr_n[3:0]) wr_bad <= wr_bad + 1;
                    if (rd_n[3:0] != 0) ord_bad <= ord_bad + 1;
                end else begin
                    mem_rdata <= mem_word(mem_addr);
                    rd_n <= rd_n + 1;
                    if (mem_addr[3:0] != rd_n[3:0]) rd_bad <= rd_bad + 1;
                    if (wr_n[3:0] != 0) ord_bad <= ord_bad + 1;
                end
            end else begin
                lat_c <= lat_c + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wait_idle();
        forever begin
            #1;
            if (!mem_req) break;
            @(negedge clk);
        end
    endtask

    // one processor access; counts memory words before release and in total
    task automatic access(input bit we, input logic [15:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output int ra, output int wa,
                          output int rt, output int wt, output int wc);
        int r0, w0;
        @(negedge clk);
        r0 = rd_n; w0 = wr_n;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        wc = 0;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
            wc++;
        end
        rd = cpu_rdata; ra = rd_n - r0; wa = wr_n - w0;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        wait_idle();
        rt = rd_n - r0; wt = wr_n - w0;
    endtask

    task automatic invalidate(input int t, input int i);
        @(negedge clk);
        inv_valid = 1'b1; inv_block = {t[4:0], i[6:0]};
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    // start a read miss, invalidate a block just after the word is delivered
    task automatic miss_with_inv(input logic [15:0] a, input int t, input int i,
                                 output logic [15:0] rd, output bit busy);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        forever begin
            #1;
            if (cpu_ready) break;
            @(negedge clk);
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        inv_valid = 1'b1; inv_block = {t[4:0], i[6:0]};
        #1 busy = mem_req;
        @(negedge clk);
        inv_valid = 1'b0;
        wait_idle();
    endtask

    initial begin
        while (cyc < 100000 && !done) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int ra, wa, rt, wt, wc;
        bit busy;

        repeat (3) @(posedge clk);
        #1;
        chk("R2", "ready in reset", int'(cpu_ready), 0);
        chk("R2", "mem_req in reset", int'(mem_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2", "ready after reset", int'(cpu_ready), 0);
        chk("R2", "mem_req after reset", int'(mem_req), 0);

        // R7 / R5 / R2: critical word at every offset, one line each
        for (int k = 0; k < 16; k++) begin
            access(1'b0, mk(1, k + 1, k), 16'h0, rd, ra, wa, rt, wt, wc);
            chk("R7", "early word data", int'(rd), int'(seed_word(mk(1, k + 1, k))));
            chk("R7", "reads before release", ra, k + 1);
            chk("R5", "fill word count", rt, 16);
            chk("R2", "first touch misses, no flush", wt, 0);
        end

        // R3 / R1: every word of one loaded line hits
        for (int k = 0; k < 16; k++) begin
            access(1'b0, mk(1, 16, k), 16'h0, rd, ra, wa, rt, wt, wc);
            chk("R3", "hit data", int'(rd), int'(seed_word(mk(1, 16, k))));
            chk("R3", "hit latency", wc, 0);
            chk("R1", "same block hits, no traffic", rt + wt, 0);
        end

        // R1 / R9: same index, other tag
        access(1'b0, mk(2, 16, 0), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R1", "other tag same index misses", rt, 16);
        chk("R9", "new block data", int'(rd), int'(seed_word(mk(2, 16, 0))));
        access(1'b0, mk(1, 16, 0), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R9", "old block replaced", rt, 16);

        // R4: write hit stays in the cache
        access(1'b1, mk(1, 5, 3), 16'hBEEF, rd, ra, wa, rt, wt, wc);
        chk("R4", "write hit latency", wc, 0);
        chk("R4", "write hit traffic", rt + wt, 0);
        chk("R4", "memory unchanged", int'(mem_word(mk(1, 5, 3))), int'(seed_word(mk(1, 5, 3))));
        access(1'b0, mk(1, 5, 3), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R4", "read back written word", int'(rd), 16'hBEEF);

        // R6 / R9: dirty victim flushed before refill
        access(1'b0, mk(3, 5, 9), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R6", "writes before release", wa, 16);
        chk("R6", "flush word count", wt, 16);
        chk("R7", "reads before release after flush", ra, 10);
        chk("R9", "replacing block data", int'(rd), int'(seed_word(mk(3, 5, 9))));
        for (int j = 0; j < 16; j++) begin
            chk("R6", "flushed word", int'(mem_word(mk(1, 5, j))),
                int'((j == 3) ? 16'hBEEF : seed_word(mk(1, 5, j))));
        end
        chk("R6", "flush precedes refill", ord_bad, 0);
        chk("R6", "flush order ascending", wr_bad, 0);
        access(1'b0, mk(1, 5, 3), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R9", "evicted block misses", rt, 16);
        chk("R6", "clean victim not flushed", wt, 0);
        chk("R6", "flushed data returns", int'(rd), 16'hBEEF);

        // R8: write allocate
        access(1'b1, mk(4, 9, 7), 16'h1234, rd, ra, wa, rt, wt, wc);
        chk("R8", "write miss fills", rt, 16);
        chk("R8", "write miss release point", ra, 8);
        chk("R8", "write miss no flush", wt, 0);
        access(1'b0, mk(4, 9, 7), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R8", "merged word", int'(rd), 16'h1234);
        chk("R8", "merged word is a hit", rt, 0);
        access(1'b0, mk(4, 9, 6), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R8", "neighbour from memory", int'(rd), int'(seed_word(mk(4, 9, 6))));
        access(1'b0, mk(5, 9, 0), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R8", "allocated line is dirty", wt, 16);
        chk("R8", "merged word reached memory", int'(mem_word(mk(4, 9, 7))), 16'h1234);

        // R10: invalidate
        access(1'b0, mk(2, 20, 0), 16'h0, rd, ra, wa, rt, wt, wc);
        invalidate(2, 20);
        access(1'b0, mk(2, 20, 1), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R10", "matching invalidate clears", rt, 16);
        invalidate(6, 20);
        access(1'b0, mk(2, 20, 2), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R10", "other tag ignored", rt + wt, 0);
        access(1'b1, mk(2, 20, 3), 16'h7777, rd, ra, wa, rt, wt, wc);
        invalidate(2, 20);
        access(1'b0, mk(2, 20, 3), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R10", "dirty data discarded, no flush", wt, 0);
        chk("R10", "refetched after invalidate", rt, 16);
        chk("R10", "memory copy returned", int'(rd), int'(seed_word(mk(2, 20, 3))));

        // R11: invalidate during refill
        miss_with_inv(mk(7, 30, 2), 7, 30, rd, busy);
        chk("R11", "word delivered", int'(rd), int'(seed_word(mk(7, 30, 2))));
        chk("R11", "refill still running", int'(busy), 1);
        access(1'b0, mk(7, 30, 2), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R11", "refilled line ends invalid", rt, 16);
        miss_with_inv(mk(7, 31, 4), 6, 31, rd, busy);
        chk("R11", "refill running for other tag", int'(busy), 1);
        access(1'b0, mk(7, 31, 5), 16'h0, rd, ra, wa, rt, wt, wc);
        chk("R11", "other tag leaves line valid", rt + wt, 0);
        chk("R11", "data after other invalidate", int'(rd), int'(seed_word(mk(7, 31, 5))));

        // R12 / R5: one word per acknowledge, addresses in order
        chk("R12", "refill order", rd_bad, 0);
        chk("R12", "flush order", wr_bad, 0);
        chk("R5", "no interleaving", ord_bad, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule